// File: doc/BRIEF.md
# Raster Display Status and Interrupt Unit

This block holds the run/stop control, the sticky event flags and the interrupt logic of a raster panel controller. Event pulses arrive from the timing and fetch logic (frame end, vertical sync, FIFO underflow, sync loss, AC-bias count, line match and palette loaded). While the controller runs, these pulses are latched into a status register. A single interrupt line combines each flag with its enable bit in the control register.

Stopping is graceful. When software clears the enable bit, the controller stays busy until the next frame-end pulse. It then goes idle and raises the completion flag, which stays set until the controller is enabled again. The fatal flags (underflow, sync loss) are cleared by the disable itself. The informational flags are cleared by writing zero at their positions in the status register. How the line and palette flags are cleared depends on control fields.

Top module: `raster_evt_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, and `busyOut` and `irqOut` are 0.
- R2: A write with `regAddr`=0 stores `regWdata` in the control register, and a read with `regAddr`=0 returns it. Bit 0 is run enable. Bit 7 is TFT mode (stored only). Bit 2 is the vsync interrupt enable, bit 3 the completion interrupt enable, bit 4 the palette interrupt enable, bit 5 mutes the line interrupt and bit 6 is the line interrupt enable. Bit 10 selects the line-flag clear mode. Bits 12:11 hold the load mode, where 2'b01 means palette only.
- R3: A control write that sets bit 0 while it is 0 makes `busyOut` 1 on the next cycle and clears the completion flag (status bit 0).
- R4: A control write that clears bit 0 while it is 1 leaves `busyOut` at 1 until a frame-end pulse. On the edge that samples that pulse, `busyOut` drops and status bit 0 sets. Setting bit 0 again before the frame-end pulse cancels the stop: the unit stays busy and status bit 0 stays 0.
- R5: While busy, each event pulse sets its status bit on the next edge: vsync at bit 1, sync lost at bit 2, AC-bias at bit 3, line match at bit 4, underflow at bit 5, palette loaded at bit 6. While idle, event pulses are ignored.
- R6: A write with `regAddr`=1 clears status bits 1 and 3 where the written bit is 0, and keeps them where it is 1. It never changes bits 0, 2 or 5.
- R7: Status bits 2 and 5 are cleared by the control write that clears the run enable.
- R8: Status bit 6 is cleared by a status write with bit 6 at 0 only when the load mode is 2'b01. In any other load mode, such a write leaves it set and the disabling control write clears it.
- R9: With control bit 10 at 0, status bit 4 is cleared like bit 1. With control bit 10 at 1, status writes leave it set and a frame-end pulse clears it.
- R10: An event pulse that lands in the same cycle as a clear of its flag leaves the flag set.
- R11: `irqOut` = (st1&c2) | (st0&c3) | (st6&c4) | (st4&c6&~c5) | st2 | st5, where stN is status bit N and cN is control bit N. AC-bias never raises the interrupt.
- R12: A read with `regAddr`=1 returns the status register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects control, 1 selects status |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` |
| evFrameEnd | input | 1 | Frame-end pulse |
| evVsync | input | 1 | Vertical sync pulse |
| evSyncLost | input | 1 | Sync-lost pulse |
| evAcBias | input | 1 | AC-bias count pulse |
| evLineMatch | input | 1 | Line-match pulse |
| evUnderflow | input | 1 | FIFO underflow pulse |
| evPalLoaded | input | 1 | Palette-loaded pulse |
| irqOut | output | 1 | Interrupt request |
| busyOut | output | 1 | Controller running or draining |

## Verification
The main sweep runs every combination of the six flag-setting events against every combination of the five control enable bits. After each combination it compares the latched status and the interrupt line with values computed from the enable equation. This separates the status bit positions from one another and checks that mute and error terms combine correctly. Each sweep pass then performs a disable, a status clear and a frame end, so every pass also checks the deferred stop and the completion flag. Directed sequences cover the remaining cases: cancelling a stop, events arriving while idle, the palette and line clear modes, and a set colliding with a clear.

// File: rtl/raster_evt_pkg.sv
package raster_evt_pkg;
  localparam int ST_W        = 7;
  localparam int ST_DONE     = 0;
  localparam int ST_VSYNC    = 1;
  localparam int ST_SYNCLOST = 2;
  localparam int ST_ACB      = 3;
  localparam int ST_LINE     = 4;
  localparam int ST_UNDER    = 5;
  localparam int ST_PAL      = 6;

  localparam int CT_EN        = 0;
  localparam int CT_IE_VSYNC  = 2;
  localparam int CT_IE_DONE   = 3;
  localparam int CT_IE_PAL    = 4;
  localparam int CT_LINE_MUTE = 5;
  localparam int CT_IE_LINE   = 6;
  localparam int CT_TFT       = 7;
  localparam int CT_LINE_CLR  = 10;
  localparam int CT_LMODE_LO  = 11;

  localparam logic [1:0] LM_PAL_ONLY = 2'b01;

  typedef struct packed {
    logic enRise;
    logic enFall;
    logic stopDone;
  } ctlStrobe_t;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_DRAIN = 2'd2} runState_t;
endpackage

// File: rtl/raster_evt_ctrl.sv
module raster_evt_ctrl
  import raster_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regAddr,
  input  logic       wrEnBit,
  input  logic       ctrlEn,
  input  logic       frameEnd,
  output ctlStrobe_t strobe,
  output logic       busy
);
  runState_t state, stateNxt;
  logic wrCtrl;

  assign wrCtrl = regWr && !regAddr;

  always_comb begin
    strobe.enRise   = wrCtrl && wrEnBit && !ctrlEn;
    strobe.enFall   = wrCtrl && !wrEnBit && ctrlEn;
    strobe.stopDone = (state == S_DRAIN) && frameEnd && !strobe.enRise;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:  if (strobe.enRise) stateNxt = S_RUN;
      S_RUN:   if (strobe.enFall) stateNxt = S_DRAIN;
      S_DRAIN: begin
        if (strobe.enRise)        stateNxt = S_RUN;
        else if (strobe.stopDone) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != S_IDLE);

  assert_busy_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWr && !regAddr && wrEnBit));
  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(frameEnd));
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameEnd) |=> busy);
endmodule

// File: rtl/raster_evt_dp.sv
module raster_evt_dp
  import raster_evt_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [ST_W-1:0]   evIn,
  input  ctlStrobe_t        strobe,
  input  logic              busy,
  output logic              ctrlEn,
  output logic              irqOut
);
  logic [DATA_W-1:0] ctrlReg;
  logic [ST_W-1:0]   status, setVec, clrVec;
  logic wrCtrl, wrSt, palOnly, lineByFrame, anyEv;

  assign wrCtrl      = regWr && !regAddr;
  assign wrSt        = regWr && regAddr;
  assign ctrlEn      = ctrlReg[CT_EN];
  assign palOnly     = ctrlReg[CT_LMODE_LO+1:CT_LMODE_LO] == LM_PAL_ONLY;
  assign lineByFrame = ctrlReg[CT_LINE_CLR];
  assign anyEv       = |evIn;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= regWdata;
  end

  always_comb begin
    setVec          = evIn & {ST_W{busy}};
    setVec[ST_DONE] = strobe.stopDone;
    clrVec              = '0;
    clrVec[ST_DONE]     = strobe.enRise;
    clrVec[ST_VSYNC]    = wrSt && !regWdata[ST_VSYNC];
    clrVec[ST_ACB]      = wrSt && !regWdata[ST_ACB];
    clrVec[ST_SYNCLOST] = strobe.enFall;
    clrVec[ST_UNDER]    = strobe.enFall;
    clrVec[ST_LINE]     = lineByFrame ? evIn[0] : (wrSt && !regWdata[ST_LINE]);
    clrVec[ST_PAL]      = palOnly ? (wrSt && !regWdata[ST_PAL]) : strobe.enFall;
  end

  for (genvar b = 0; b < ST_W; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) status[b] <= 1'b0;
      else       status[b] <= (status[b] & ~clrVec[b]) | setVec[b];
    end
  end

  assign irqOut = (status[ST_VSYNC] & ctrlReg[CT_IE_VSYNC])
                | (status[ST_DONE]  & ctrlReg[CT_IE_DONE])
                | (status[ST_PAL]   & ctrlReg[CT_IE_PAL])
                | (status[ST_LINE]  & ctrlReg[CT_IE_LINE] & ~ctrlReg[CT_LINE_MUTE])
                | status[ST_SYNCLOST] | status[ST_UNDER];

  assign regRdata = regAddr ? {{(DATA_W-ST_W){1'b0}}, status} : ctrlReg;

  assert_done_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_DONE]) |-> $past(strobe.stopDone));
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[ST_UNDER]) |-> $past(regWr && !regAddr && !regWdata[CT_EN]));
  assert_idle_ignore_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_VSYNC]) |-> $past(busy && evIn[ST_VSYNC]));
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(regWr || anyEv || strobe.stopDone));
  assert_status_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && !anyEv) |=> $stable(status));
endmodule

// File: rtl/raster_evt_top.sv
module raster_evt_top
  import raster_evt_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evFrameEnd,
  input  logic              evVsync,
  input  logic              evSyncLost,
  input  logic              evAcBias,
  input  logic              evLineMatch,
  input  logic              evUnderflow,
  input  logic              evPalLoaded,
  output logic              irqOut,
  output logic              busyOut
);
  ctlStrobe_t       strobe;
  logic             ctrlEn;
  logic [ST_W-1:0]  evVec;

  assign evVec = {evPalLoaded, evUnderflow, evLineMatch, evAcBias,
                  evSyncLost, evVsync, evFrameEnd};

  raster_evt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wrEnBit(regWdata[CT_EN]), .ctrlEn(ctrlEn), .frameEnd(evFrameEnd),
    .strobe(strobe), .busy(busyOut)
  );

  raster_evt_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evIn(evVec),
    .strobe(strobe), .busy(busyOut), .ctrlEn(ctrlEn), .irqOut(irqOut)
  );
endmodule

// File: tb/raster_evt_top_tb_top.sv
module raster_evt_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic regAddr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [6:0] ev = '0;
  logic irqOut, busyOut;
  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  raster_evt_top dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .evFrameEnd(ev[0]), .evVsync(ev[1]), .evSyncLost(ev[2]), .evAcBias(ev[3]),
    .evLineMatch(ev[4]), .evUnderflow(ev[5]), .evPalLoaded(ev[6]),
    .irqOut(irqOut), .busyOut(busyOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic a, input logic [15:0] d, input logic [6:0] e);
    regWr = wr; regAddr = a; regWdata = d; ev = e;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0; ev = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  function automatic logic expIrq(input logic [6:0] st, input logic [15:0] c);
    return (st[1] & c[2]) | (st[0] & c[3]) | (st[6] & c[4]) |
           (st[4] & c[6] & ~c[5]) | st[2] | st[5];
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    chk("R1 busy", busyOut, 0);
    chk("R1 irq", irqOut, 0);

    // R5 events while idle are ignored
    step(0, 0, 0, 7'h7E);
    rd(1, v); chk("R5 idle ignore", v, 0);

    // R2 control readback (enable left 0)
    step(1, 0, 16'h1CF4, 0);
    rd(0, v); chk("R2 ctrl readback", v, 16'h1CF4);
    chk("R2 no busy", busyOut, 0);
    step(1, 0, 16'h0000, 0);

    // main sweep: enable patterns x event masks (R3 R5 R11 R12 R4 R7)
    for (int ien = 0; ien < 32; ien++) begin
      for (int k = 0; k < 64; k++) begin
        logic [15:0] c;
        logic [6:0] m;
        c = 16'h1000 | 16'(ien << 2) | 16'h1;
        m = 7'(k << 1);
        step(1, 0, c, 0);
        step(0, 0, 0, m);
        rd(1, v);
        chk("R5 R12 status latch", v, {9'd0, m});
        chk("R11 irq", irqOut, expIrq(m, c));
        step(1, 0, c & 16'hFFFE, 0);
        step(1, 1, 16'h0000, 0);
        step(0, 0, 0, 7'h01);
        rd(1, v);
        chk("R4 R7 teardown", {busyOut, v[6:0]}, 8'h01);
      end
    end

    // R3 enable clears DONE, R4 deferred stop
    step(1, 0, 16'h0001, 0);
    rd(1, v); chk("R3 done cleared", v, 0);
    chk("R3 busy", busyOut, 1);
    step(1, 0, 16'h0000, 0);
    repeat (5) @(negedge clk);
    rd(1, v); chk("R4 still draining", {busyOut, v[0]}, 2'b10);
    step(0, 0, 0, 7'h01);
    rd(1, v); chk("R4 stop at frame end", {busyOut, v[0]}, 2'b01);
    // R4 cancel
    step(1, 0, 16'h0001, 0);
    step(1, 0, 16'h0000, 0);
    step(1, 0, 16'h0001, 0);
    step(0, 0, 0, 7'h01);
    rd(1, v); chk("R4 cancel", {busyOut, v[0]}, 2'b10);

    // R6 writes of 1 keep, DONE/errors untouched by status write
    step(0, 0, 0, 7'h2E);
    step(1, 1, 16'h000A, 0);
    rd(1, v); chk("R6 keep ones", v, 16'h002E);
    step(1, 1, 16'h0000, 0);
    rd(1, v); chk("R6 errors stay", v, 16'h0024);

    // R8 palette in frame mode: status write does not clear
    step(1, 0, 16'h1001, 0);
    step(0, 0, 0, 7'h40);
    step(1, 1, 16'h0000, 0);
    rd(1, v); chk("R8 frame mode keep", v[6], 1);
    step(1, 0, 16'h1000, 0);
    rd(1, v); chk("R8 R7 disable clears", v, 0);
    step(0, 0, 0, 7'h01);
    // R8 palette-only mode
    step(1, 0, 16'h0801, 0);
    step(0, 0, 0, 7'h40);
    step(1, 1, 16'h0000, 0);
    rd(1, v); chk("R8 pal mode clear", v[6], 0);

    // R9 line clear select
    step(1, 0, 16'h0401, 0);
    step(0, 0, 0, 7'h10);
    step(1, 1, 16'h0000, 0);
    rd(1, v); chk("R9 write ignored", v[4], 1);
    step(0, 0, 0, 7'h01);
    rd(1, v); chk("R9 frame clears", v[4], 0);

    // R10 set beats clear
    step(1, 0, 16'h0001, 0);
    step(1, 1, 16'h0000, 7'h02);
    rd(1, v); chk("R10 set wins", v[1], 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule